// File: doc/BRIEF.md
# Request/Acknowledge Bus to Avalon-MM Master Bridge

This bridge sits between a processor's request/acknowledge data port and a reduced Avalon-MM master port. A one-cycle read or write strobe, with a byte address, an access size and right-justified write data, starts a single bus transfer. The bridge then holds the Avalon command steady for as many wait states as the slave asks for. When the slave releases `waitrequest`, the bridge closes the transfer and returns a one-cycle acknowledge.

Only one transfer is in flight at a time. The bridge does not issue bursts, does not pipeline commands and does not track reads that return later. It works out the byte lanes from the low address bits and the size code. It moves write data onto those lanes and, in its default variant, shifts read data back down to bit 0. Lanes that were not enabled read as zero.

Top module: `sbus_avmm_bridge`

## Requirements
- R1: When `req_rd` or `req_wr` is high at a clock edge while the bridge is idle, the request is latched. From the next cycle `avm_read` (read) or `avm_write` (write) is high.
- R2: While a command is asserted and `avm_waitrequest` is high, the next cycle shows the same `avm_address`, `avm_byteenable`, `avm_writedata`, `avm_read` and `avm_write`.
- R3: `avm_byteenable` is computed from the size code `req_size` (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) and the byte offset `req_addr[1:0]`. Lane i is enabled when offset <= i < offset + size in bytes. Lanes beyond lane 3 are dropped, so unaligned accesses within a word are supported.
- R4: `avm_writedata` is `req_wdata` shifted left by 8 x offset bits and truncated to 32 bits.
- R5: On a read, `rsp_rdata` is formed from `avm_readdata` in three steps. It is sampled at the edge where `avm_waitrequest` is low, ANDed with the enabled lanes and shifted right by 8 x offset bits. It is valid while `rsp_ack` is high.
- R6: A transfer completes at the clock edge where `avm_waitrequest` is low while a command is asserted. `rsp_ack` is high for exactly the one following cycle, and that cycle has `avm_read` and `avm_write` low.
- R7: `avm_read` and `avm_write` are never high together, and both are low while no transfer is open.
- R8: Strobes that arrive while a transfer is open are ignored. They issue no command, produce no extra acknowledge and change no memory.
- R9: If `req_rd` and `req_wr` are both high when a request is accepted, the write is performed.
- R10: Synchronous active-high `rst` returns the bridge to idle with `avm_read`, `avm_write` and `rsp_ack` low.
- R11: `avm_address` is the latched byte address with its two low bits forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_addr | input | 32 | Processor byte address |
| req_wdata | input | 32 | Right-justified write data |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2/3 word |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| rsp_rdata | output | 32 | Read data, valid with acknowledge |
| rsp_ack | output | 1 | One-cycle completion pulse |
| avm_address | output | 32 | Word-aligned bus byte address |
| avm_read | output | 1 | Bus read command |
| avm_write | output | 1 | Bus write command |
| avm_writedata | output | 32 | Lane-positioned write data |
| avm_byteenable | output | 4 | Enabled byte lanes |
| avm_readdata | input | 32 | Slave read data |
| avm_waitrequest | input | 1 | Slave stall |

## Verification
The properties assume that the slave drives `avm_waitrequest` to a known level in every cycle a command is open. They also assume that `avm_readdata` is valid at the completing edge. They place no limit on how long the slave stalls.

The stimulus keeps to these assumptions with a bench slave. Its stall level is redrawn from a seeded random source on every falling edge, and its read data comes from a word array indexed by the bus address. The bench raises each processor strobe for exactly one cycle. A strobe is reasserted during an open transfer only in the directed case that checks it is ignored.

// File: rtl/sbus_avmm_pkg.sv
package sbus_avmm_pkg;

   typedef enum logic {
      BR_IDLE = 1'b0,
      BR_BUSY = 1'b1
   } br_state_t;

   // Size code: number of bytes is 2**code, saturated at the bus width.
   localparam int SIZE_CODE_W = 2;

endpackage

// File: rtl/sbus_lane_gen.sv
module sbus_lane_gen #(
   parameter int LANES  = 4,
   parameter int OFF_W  = 2,
   parameter int SIZE_W = 2
) (
   input  logic [OFF_W-1:0]  offset,
   input  logic [SIZE_W-1:0] size,
   output logic [LANES-1:0]  lanes
);

   int off_i;
   int span_i;

   always_comb begin
      off_i = int'(offset);
      if (int'(size) >= OFF_W) begin
         span_i = LANES;
      end else begin
         span_i = 1 << size;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lanes[i] = (i >= off_i) && (i < off_i + span_i);
   end

endmodule

// File: rtl/sbus_data_align.sv
module sbus_data_align #(
   parameter int DATA_W     = 32,
   parameter int LANES      = 4,
   parameter int OFF_W      = 2,
   parameter bit SHIFT_DATA = 1'b1
) (
   input  logic [OFF_W-1:0]  wr_offset,
   input  logic [DATA_W-1:0] wr_data_in,
   output logic [DATA_W-1:0] wr_data_out,
   input  logic [OFF_W-1:0]  rd_offset,
   input  logic [LANES-1:0]  rd_lanes,
   input  logic [DATA_W-1:0] rd_data_in,
   output logic [DATA_W-1:0] rd_data_out
);

   localparam int SHAMT_W = OFF_W + 3;

   logic [DATA_W-1:0] rd_mask;
   logic [DATA_W-1:0] rd_masked;

   for (genvar i = 0; i < LANES; i++) begin : g_mask
      assign rd_mask[i*8 +: 8] = {8{rd_lanes[i]}};
   end

   assign rd_masked = rd_data_in & rd_mask;

   if (SHIFT_DATA) begin : g_shift
      logic [SHAMT_W-1:0] wr_sh;
      logic [SHAMT_W-1:0] rd_sh;
      assign wr_sh       = {wr_offset, 3'b000};
      assign rd_sh       = {rd_offset, 3'b000};
      assign wr_data_out = wr_data_in << wr_sh;
      assign rd_data_out = rd_masked >> rd_sh;
   end else begin : g_lanepos
      logic [2*OFF_W-1:0] unused_off;
      assign unused_off  = {wr_offset, rd_offset};
      assign wr_data_out = wr_data_in;
      assign rd_data_out = rd_masked;
   end

endmodule

// File: rtl/sbus_avmm_ctrl.sv
module sbus_avmm_ctrl
   import sbus_avmm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LANES  = 4,
   parameter int OFF_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_rd,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]  lanes_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              avm_waitrequest,
   input  logic [DATA_W-1:0] rdata_aligned,
   output logic [ADDR_W-1:0] avm_address,
   output logic              avm_read,
   output logic              avm_write,
   output logic [DATA_W-1:0] avm_writedata,
   output logic [LANES-1:0]  avm_byteenable,
   output logic [OFF_W-1:0]  off_q,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_ack
);

   br_state_t state_q;
   logic      is_wr_q;
   logic      accept;
   logic      finish;

   assign accept = (state_q == BR_IDLE) && (req_rd || req_wr);
   assign finish = (state_q == BR_BUSY) && !avm_waitrequest;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= BR_IDLE;
         is_wr_q <= 1'b0;
         rsp_ack <= 1'b0;
      end else begin
         rsp_ack <= finish;
         if (accept) begin
            state_q <= BR_BUSY;
            is_wr_q <= req_wr;
         end else if (finish) begin
            state_q <= BR_IDLE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         avm_address    <= '0;
         avm_writedata  <= '0;
         avm_byteenable <= '0;
         off_q          <= '0;
         rsp_rdata      <= '0;
      end else begin
         if (accept) begin
            avm_address    <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            avm_writedata  <= wdata_in;
            avm_byteenable <= lanes_in;
            off_q          <= req_addr[OFF_W-1:0];
         end
         if (finish && !is_wr_q) begin
            rsp_rdata <= rdata_aligned;
         end
      end
   end

   assign avm_read  = (state_q == BR_BUSY) && !is_wr_q;
   assign avm_write = (state_q == BR_BUSY) &&  is_wr_q;

endmodule

// File: rtl/sbus_avmm_bridge.sv
module sbus_avmm_bridge #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SIZE_W     = 2,
   parameter bit SHIFT_DATA = 1'b1,
   localparam int LANES     = DATA_W / 8,
   localparam int OFF_W     = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_rd,
   input  logic              req_wr,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_ack,
   output logic [ADDR_W-1:0] avm_address,
   output logic              avm_read,
   output logic              avm_write,
   output logic [DATA_W-1:0] avm_writedata,
   output logic [LANES-1:0]  avm_byteenable,
   input  logic [DATA_W-1:0] avm_readdata,
   input  logic              avm_waitrequest
);

   if ((DATA_W % 8) != 0 || LANES < 2 || (1 << OFF_W) != LANES) begin : g_bad_width
      $error("sbus_avmm_bridge: DATA_W must be a power-of-two number of bytes, at least 16 bits");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("sbus_avmm_bridge: ADDR_W too small for the lane offset");
   end
   if (SIZE_W < 1) begin : g_bad_size
      $error("sbus_avmm_bridge: SIZE_W must be at least 1");
   end

   logic [LANES-1:0]  lanes_req;
   logic [DATA_W-1:0] wdata_lane;
   logic [DATA_W-1:0] rdata_aligned;
   logic [OFF_W-1:0]  off_q;

   sbus_lane_gen #(
      .LANES  (LANES),
      .OFF_W  (OFF_W),
      .SIZE_W (SIZE_W)
   ) u_lanes (
      .offset (req_addr[OFF_W-1:0]),
      .size   (req_size),
      .lanes  (lanes_req)
   );

   sbus_data_align #(
      .DATA_W     (DATA_W),
      .LANES      (LANES),
      .OFF_W      (OFF_W),
      .SHIFT_DATA (SHIFT_DATA)
   ) u_align (
      .wr_offset   (req_addr[OFF_W-1:0]),
      .wr_data_in  (req_wdata),
      .wr_data_out (wdata_lane),
      .rd_offset   (off_q),
      .rd_lanes    (avm_byteenable),
      .rd_data_in  (avm_readdata),
      .rd_data_out (rdata_aligned)
   );

   sbus_avmm_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .OFF_W  (OFF_W)
   ) u_ctrl (
      .clk             (clk),
      .rst             (rst),
      .req_rd          (req_rd),
      .req_wr          (req_wr),
      .req_addr        (req_addr),
      .lanes_in        (lanes_req),
      .wdata_in        (wdata_lane),
      .avm_waitrequest (avm_waitrequest),
      .rdata_aligned   (rdata_aligned),
      .avm_address     (avm_address),
      .avm_read        (avm_read),
      .avm_write       (avm_write),
      .avm_writedata   (avm_writedata),
      .avm_byteenable  (avm_byteenable),
      .off_q           (off_q),
      .rsp_rdata       (rsp_rdata),
      .rsp_ack         (rsp_ack)
   );

endmodule

// File: rtl/sbus_avmm_chk.sv
module sbus_avmm_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LANES  = 4,
   parameter int OFF_W  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              req_rd,
   input logic              req_wr,
   input logic              rsp_ack,
   input logic [ADDR_W-1:0] avm_address,
   input logic              avm_read,
   input logic              avm_write,
   input logic [DATA_W-1:0] avm_writedata,
   input logic [LANES-1:0]  avm_byteenable,
   input logic              avm_waitrequest
);

   logic cmd;
   assign cmd = avm_read || avm_write;

   a_r7_excl: assert property (@(posedge clk) disable iff (rst)
      !(avm_read && avm_write));

   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      (cmd && avm_waitrequest) |=>
         ($stable(avm_address) && $stable(avm_byteenable) && $stable(avm_writedata)
          && $stable(avm_read) && $stable(avm_write)));

   a_r11_align: assert property (@(posedge clk) disable iff (rst)
      cmd |-> (avm_address[OFF_W-1:0] == '0));

   a_r6_ack_pulse: assert property (@(posedge clk) disable iff (rst)
      rsp_ack |=> !rsp_ack);

   a_r6_ack_after: assert property (@(posedge clk) disable iff (rst)
      (cmd && !avm_waitrequest) |=> (rsp_ack && !avm_read && !avm_write));

   a_r6_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
      !(cmd && !avm_waitrequest) |=> !rsp_ack);

   a_r1_start: assert property (@(posedge clk) disable iff (rst)
      (!cmd && (req_rd || req_wr)) |=> cmd);

   a_r9_prio: assert property (@(posedge clk) disable iff (rst)
      (!cmd && req_rd && req_wr) |=> avm_write);

   a_r8_hold_cmd: assert property (@(posedge clk) disable iff (rst)
      (avm_read && avm_waitrequest) |=> avm_read);

endmodule

bind sbus_avmm_bridge sbus_avmm_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .LANES  (LANES),
   .OFF_W  (OFF_W)
) u_chk (
   .clk             (clk),
   .rst             (rst),
   .req_rd          (req_rd),
   .req_wr          (req_wr),
   .rsp_ack         (rsp_ack),
   .avm_address     (avm_address),
   .avm_read        (avm_read),
   .avm_write       (avm_write),
   .avm_writedata   (avm_writedata),
   .avm_byteenable  (avm_byteenable),
   .avm_waitrequest (avm_waitrequest)
);

// File: tb/tb_sbus_avmm_bridge.sv
module tb_sbus_avmm_bridge;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [1:0]  req_size = '0;
   logic        req_rd = 1'b0;
   logic        req_wr = 1'b0;
   logic [31:0] rsp_rdata;
   logic        rsp_ack;
   logic [31:0] avm_address;
   logic        avm_read;
   logic        avm_write;
   logic [31:0] avm_writedata;
   logic [3:0]  avm_byteenable;
   logic [31:0] avm_readdata;
   logic        avm_waitrequest = 1'b1;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [31:0] mem [16];
   logic [31:0] shadow [16];

   always #2.5 clk = ~clk;

   sbus_avmm_bridge dut (
      .clk             (clk),
      .rst             (rst),
      .req_addr        (req_addr),
      .req_wdata       (req_wdata),
      .req_size        (req_size),
      .req_rd          (req_rd),
      .req_wr          (req_wr),
      .rsp_rdata       (rsp_rdata),
      .rsp_ack         (rsp_ack),
      .avm_address     (avm_address),
      .avm_read        (avm_read),
      .avm_write       (avm_write),
      .avm_writedata   (avm_writedata),
      .avm_byteenable  (avm_byteenable),
      .avm_readdata    (avm_readdata),
      .avm_waitrequest (avm_waitrequest)
   );

   function automatic logic [31:0] init_word(int i);
      return (i * 32'h0101_0101) ^ 32'hA5C3_0F11;
   endfunction

   // Bench slave: word memory, writes at the accepting edge.
   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
      end else if (avm_write && !avm_waitrequest) begin
         for (int b = 0; b < 4; b++)
            if (avm_byteenable[b]) mem[avm_address[5:2]][b*8 +: 8] <= avm_writedata[b*8 +: 8];
      end
   end
   assign avm_readdata = avm_read ? mem[avm_address[5:2]] : 32'hDEAD_BEEF;

   always @(posedge clk) cycles <= cycles + 1;

   function automatic logic [3:0] exp_lanes(logic [1:0] off, logic [1:0] size);
      int span;
      logic [3:0] l;
      span = (size >= 2) ? 4 : (1 << size);
      for (int i = 0; i < 4; i++) l[i] = (i >= int'(off)) && (i < int'(off) + span);
      return l;
   endfunction

   function automatic logic [31:0] lane_mask(logic [3:0] l);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{l[i]}};
      return m;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One transfer. inject=1 raises a write strobe to word inj_word while busy.
   task automatic xfer(bit wr, bit both, logic [31:0] addr, logic [1:0] size,
                       logic [31:0] wdata, bit inject, logic [31:0] inj_addr);
      logic [3:0]  l;
      logic [1:0]  off;
      int          n;
      bit          done;
      bit          injected;
      off = addr[1:0];
      l   = exp_lanes(off, size);
      @(negedge clk);
      req_addr  = addr;
      req_size  = size;
      req_wdata = wdata;
      req_wr    = wr | both;
      req_rd    = !wr | both;
      avm_waitrequest = ($urandom % 3) != 0;
      @(negedge clk);
      req_rd = 1'b0;
      req_wr = 1'b0;
      check("R1 command raised", {30'd0, avm_read, avm_write}, (wr | both) ? 32'd1 : 32'd2);
      check("R11 word address", avm_address, {addr[31:2], 2'b00});
      check("R3 byteenable", {28'd0, avm_byteenable}, {28'd0, l});
      if (wr | both) check("R4 write lanes", avm_writedata, wdata << (8 * off));
      n = 0;
      done = 1'b0;
      injected = 1'b0;
      while (!done) begin
         if (rsp_ack) begin
            done = 1'b1;
         end else begin
            if (inject && !injected) begin
               injected  = 1'b1;
               req_addr  = inj_addr;
               req_size  = 2'd2;
               req_wdata = 32'h5A5A_5A5A;
               req_wr    = 1'b1;
            end else begin
               req_wr = 1'b0;
               req_addr = addr;
            end
            avm_waitrequest = ($urandom % 3) != 0;
            @(negedge clk);
            n++;
            if (n > 200) begin
               check("R6 ack timeout", 32'd0, 32'd1);
               done = 1'b1;
            end
         end
      end
      req_wr = 1'b0;
      check("R6 ack idle bus", {30'd0, avm_read, avm_write}, 32'd0);
      if (wr | both) begin
         for (int b = 0; b < 4; b++)
            if (l[b]) shadow[addr[5:2]][b*8 +: 8] = (wdata << (8 * off)) >> (8 * b);
      end else begin
         check("R5 read data", rsp_rdata, (shadow[addr[5:2]] & lane_mask(l)) >> (8 * off));
      end
      avm_waitrequest = 1'b1;
      @(negedge clk);
      check("R6 ack single cycle", {31'd0, rsp_ack}, 32'd0);
      if (inject)
         check("R8 no extra command", {30'd0, avm_read, avm_write}, 32'd0);
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
      repeat (3) @(negedge clk);
      check("R10 reset bus low", {30'd0, avm_read, avm_write}, 32'd0);
      check("R10 reset ack low", {31'd0, rsp_ack}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R7 idle bus low", {30'd0, avm_read, avm_write}, 32'd0);
      // Directed: bytes at every offset, unaligned halves and words
      for (int o = 0; o < 4; o++) xfer(1'b1, 1'b0, 32'h10 + o, 2'd0, 32'h0000_00C0 + o, 1'b0, 0);
      for (int o = 0; o < 4; o++) xfer(1'b0, 1'b0, 32'h10 + o, 2'd0, 0, 1'b0, 0);
      xfer(1'b1, 1'b0, 32'h23, 2'd1, 32'h0000_BEEF, 1'b0, 0);
      xfer(1'b0, 1'b0, 32'h23, 2'd1, 0, 1'b0, 0);
      xfer(1'b1, 1'b0, 32'h31, 2'd2, 32'h1234_5678, 1'b0, 0);
      xfer(1'b0, 1'b0, 32'h32, 2'd3, 0, 1'b0, 0);
      // R9: both strobes -> write
      xfer(1'b1, 1'b1, 32'h08, 2'd2, 32'hCAFE_F00D, 1'b0, 0);
      xfer(1'b0, 1'b0, 32'h08, 2'd2, 0, 1'b0, 0);
      // R8: write strobe during an open read must not change word 0x3C
      xfer(1'b0, 1'b0, 32'h04, 2'd2, 0, 1'b1, 32'h3C);
      xfer(1'b0, 1'b0, 32'h3C, 2'd2, 0, 1'b0, 0);
      // Random mix
      for (int k = 0; k < 400; k++) begin
         xfer(($urandom % 2) == 1, 1'b0, $urandom % 64, 2'($urandom % 4), $urandom, 1'b0, 0);
      end
      for (int w = 0; w < 16; w++) xfer(1'b0, 1'b0, w * 4, 2'd2, 0, 1'b0, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule